// File: doc/BRIEF.md
# Interrupt Controller Setup Sequencer

This block sits behind the processor write port of a programmable eight-input interrupt controller. It watches byte writes, each made of a chip select, a write strobe, one address bit and an 8-bit data byte. It walks through a setup sequence of two to four bytes. The first byte of the sequence says whether the third byte (cascade wiring) and the fourth byte (processor and end-of-interrupt options) will follow. Out of the sequence the block holds the controller's configuration: single or cascade use, trigger type, vector base, slave wiring, and the option flags. It presents this configuration to the priority and vector logic next to it.

A start byte can be written at any time. It restarts the sequence and resets the operating state it affects. The block clears the mask, special mask mode, the automatic-rotation flag and the read-register selection itself. It also emits a one-cycle clear pulse, on which the neighbouring logic clears its in-service bits and edge latches and resets its priority order to input 0 highest. Once the sequence is complete, writes are routed to operational registers: address 1 loads the mask, and address 0 carries either an end-of-interrupt/rotation command or a read/poll/special-mask command. Writes are accepted in every cycle. There is no back-pressure, because the processor port has no wait path. Every output is a register and changes on the clock edge that takes the write.

Top module: `pic_init_seq`

## Requirements
- R1: After reset, cfg_ready, every configuration output, irq_mask, spec_mask_mode, read_isr_sel, rot_in_aeoi and all strobes are 0.
- R2: A write with bus_addr=0 and data bit 4 set is a start byte in any state. It drops cfg_ready and loads cfg_single from bit 1, cfg_adi from bit 2, cfg_level from bit 3 (1 = level, 0 = edge) and cfg_vec_base[2:0] from bits 7:5. Bit 0 says whether a fourth byte follows.
- R3: A start byte clears irq_mask, spec_mask_mode, read_isr_sel (selects the request register) and rot_in_aeoi, and raises init_clr for exactly one cycle.
- R4: The next address-1 write after a start byte is always the second byte, and it loads cfg_vec_base[10:3].
- R5: The third byte is expected only when cfg_single=0. It is taken into cfg_slave_map, and cfg_slave_id shows its bits 2:0.
- R6: The fourth byte is expected only when start-byte bit 0 is 1. It loads cfg_cpu16 from bit 0, cfg_aeoi from bit 1, cfg_buf_master from bit 2, cfg_buffered from bit 3 and cfg_sfnm from bit 4. Every start byte clears these five flags, so they stay 0 when no fourth byte is expected.
- R7: cfg_ready rises on the edge that takes the last expected byte. Before that, address-1 writes never touch irq_mask, and address-0 writes with bit 4 clear are ignored.
- R8: When cfg_ready=1, an address-1 write loads irq_mask.
- R9: When ready, an address-0 byte with bits 4:3 = 00 pulses cmd_stb for one cycle with cmd_byte set to that byte. Bits 7:5 = 100 set rot_in_aeoi and bits 7:5 = 000 clear it.
- R10: When ready, an address-0 byte with bits 4:3 = 01 updates cmd_byte. Bit 2 set pulses poll_stb, and the read select then does not change. Otherwise bit 1 set loads read_isr_sel from bit 0. Bit 6 set loads spec_mask_mode from bit 5.
- R11: A cycle without both bus_sel and bus_wr changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Chip select, active high |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_addr | input | 1 | Register address bit |
| bus_wdata | input | 8 | Write data |
| cfg_ready | output | 1 | Setup sequence complete |
| cfg_single | output | 1 | Single controller, no cascade |
| cfg_level | output | 1 | Level triggering selected |
| cfg_adi | output | 1 | Call address interval flag |
| cfg_vec_base | output | 11 | Vector base {second byte, start bits 7:5} |
| cfg_slave_map | output | 8 | Third byte, master view: inputs with slaves |
| cfg_slave_id | output | 3 | Third byte, slave view: own identity |
| cfg_aeoi | output | 1 | Automatic end of interrupt |
| cfg_buf_master | output | 1 | Master when buffered |
| cfg_buffered | output | 1 | Buffered mode |
| cfg_sfnm | output | 1 | Special fully nested mode |
| cfg_cpu16 | output | 1 | 16-bit processor vector mode |
| irq_mask | output | 8 | Interrupt mask |
| spec_mask_mode | output | 1 | Special mask mode |
| read_isr_sel | output | 1 | Read command targets in-service register |
| rot_in_aeoi | output | 1 | Rotate on automatic EOI |
| init_clr | output | 1 | One-cycle clear pulse to neighbours |
| cmd_stb | output | 1 | EOI/rotation command pulse |
| cmd_byte | output | 8 | Last operational command byte |
| poll_stb | output | 1 | Poll command pulse |

## Verification
On every cycle, the assertions check four things. A start byte produces the clear pulse and an empty mask on the next edge. The option flags are zero after a start byte that announces no fourth byte. The mask does not move while the sequence is unfinished. Idle cycles leave cfg_ready unchanged. The sequence itself is shown by the bench's scenarios: each combination of the two skip flags, a restart part-way through the sequence, polls that override read selection, and the rotate flag's set and clear codes. For each, the bench checks the ordering of bytes and the values latched against its own model.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_RUN  = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic start;
    logic hi_wr;
    logic cmd_a;
    logic cmd_b;
  } wr_cls_t;

  typedef struct packed {
    logic cpu16;
    logic aeoi;
    logic buf_master;
    logic buffered;
    logic sfnm;
  } opt_t;
endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
  import pic_init_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic         wr,
  input  logic         addr,
  input  logic [W-1:0] data,
  output wr_cls_t      cls
);
  logic go;
  always_comb begin
    go        = sel & wr;
    cls.start = go & ~addr & data[4];
    cls.hi_wr = go & addr;
    cls.cmd_a = go & ~addr & ~data[4] & ~data[3];
    cls.cmd_b = go & ~addr & ~data[4] & data[3];
  end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_init_pkg::*;
#(
  parameter int W    = 8,
  parameter int LO_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  wr_cls_t         cls,
  input  logic [W-1:0]    data,
  output logic            ready,
  output logic            single,
  output logic            level,
  output logic            adi,
  output logic [W+LO_W-1:0] vec_base,
  output logic [W-1:0]    casc,
  output opt_t            opt
);
  seq_st_e st;
  logic    want4;

  assign ready = (st == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      want4    <= 1'b0;
      single   <= 1'b0;
      level    <= 1'b0;
      adi      <= 1'b0;
      vec_base <= '0;
      casc     <= '0;
      opt      <= '0;
    end else if (cls.start) begin
      st                   <= ST_W2;
      want4                <= data[0];
      single               <= data[1];
      adi                  <= data[2];
      level                <= data[3];
      vec_base[LO_W-1:0]   <= data[W-1:W-LO_W];
      opt                  <= '0;
    end else if (cls.hi_wr) begin
      unique case (st)
        ST_W2: begin
          vec_base[W+LO_W-1:LO_W] <= data;
          st <= !single ? ST_W3 : (want4 ? ST_W4 : ST_RUN);
        end
        ST_W3: begin
          casc <= data;
          st   <= want4 ? ST_W4 : ST_RUN;
        end
        ST_W4: begin
          opt.cpu16      <= data[0];
          opt.aeoi       <= data[1];
          opt.buf_master <= data[2];
          opt.buffered   <= data[3];
          opt.sfnm       <= data[4];
          st             <= ST_RUN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_op_regs.sv
module pic_op_regs
  import pic_init_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_cls_t      cls,
  input  logic         ready,
  input  logic [W-1:0] data,
  output logic [W-1:0] mask,
  output logic         smm,
  output logic         rd_isr,
  output logic         rot,
  output logic         clr_pulse,
  output logic         cmd_pulse,
  output logic         poll_pulse,
  output logic [W-1:0] cmd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask       <= '0;
      smm        <= 1'b0;
      rd_isr     <= 1'b0;
      rot        <= 1'b0;
      clr_pulse  <= 1'b0;
      cmd_pulse  <= 1'b0;
      poll_pulse <= 1'b0;
      cmd        <= '0;
    end else begin
      clr_pulse  <= cls.start;
      cmd_pulse  <= 1'b0;
      poll_pulse <= 1'b0;
      if (cls.start) begin
        mask   <= '0;
        smm    <= 1'b0;
        rd_isr <= 1'b0;
        rot    <= 1'b0;
      end else if (ready) begin
        if (cls.hi_wr) mask <= data;
        if (cls.cmd_a) begin
          cmd       <= data;
          cmd_pulse <= 1'b1;
          if (data[7:5] == 3'b100) rot <= 1'b1;
          if (data[7:5] == 3'b000) rot <= 1'b0;
        end
        if (cls.cmd_b) begin
          cmd <= data;
          if (data[2]) poll_pulse <= 1'b1;
          else if (data[1]) rd_isr <= data[0];
          if (data[6]) smm <= data[5];
        end
      end
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_init_pkg::*;
#(
  parameter int NUM_IR = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic                      bus_addr,
  input  logic [7:0]                bus_wdata,
  output logic                      cfg_ready,
  output logic                      cfg_single,
  output logic                      cfg_level,
  output logic                      cfg_adi,
  output logic [10:0]               cfg_vec_base,
  output logic [NUM_IR-1:0]         cfg_slave_map,
  output logic [$clog2(NUM_IR)-1:0] cfg_slave_id,
  output logic                      cfg_aeoi,
  output logic                      cfg_buf_master,
  output logic                      cfg_buffered,
  output logic                      cfg_sfnm,
  output logic                      cfg_cpu16,
  output logic [NUM_IR-1:0]         irq_mask,
  output logic                      spec_mask_mode,
  output logic                      read_isr_sel,
  output logic                      rot_in_aeoi,
  output logic                      init_clr,
  output logic                      cmd_stb,
  output logic [7:0]                cmd_byte,
  output logic                      poll_stb
);
  localparam int ID_W = $clog2(NUM_IR);
  localparam int LO_W = 3;

  wr_cls_t cls;
  opt_t    opt;
  logic [DW-1:0] casc;
  logic [DW-1:0] mask_full;

  pic_wr_decode #(.W(DW)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .data(bus_wdata), .cls(cls)
  );

  pic_init_fsm #(.W(DW), .LO_W(LO_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cls(cls), .data(bus_wdata),
    .ready(cfg_ready), .single(cfg_single), .level(cfg_level), .adi(cfg_adi),
    .vec_base(cfg_vec_base), .casc(casc), .opt(opt)
  );

  pic_op_regs #(.W(DW)) u_ops (
    .clk(clk), .rst_n(rst_n), .cls(cls), .ready(cfg_ready), .data(bus_wdata),
    .mask(mask_full), .smm(spec_mask_mode), .rd_isr(read_isr_sel),
    .rot(rot_in_aeoi), .clr_pulse(init_clr), .cmd_pulse(cmd_stb),
    .poll_pulse(poll_stb), .cmd(cmd_byte)
  );

  assign cfg_slave_map  = casc[NUM_IR-1:0];
  assign cfg_slave_id   = casc[ID_W-1:0];
  assign irq_mask       = mask_full[NUM_IR-1:0];
  assign cfg_cpu16      = opt.cpu16;
  assign cfg_aeoi       = opt.aeoi;
  assign cfg_buf_master = opt.buf_master;
  assign cfg_buffered   = opt.buffered;
  assign cfg_sfnm       = opt.sfnm;
endmodule

// File: rtl/pic_init_seq_chk.sv
module pic_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic       cfg_ready,
  input logic       cfg_aeoi,
  input logic       cfg_buf_master,
  input logic       cfg_buffered,
  input logic       cfg_sfnm,
  input logic       cfg_cpu16,
  input logic [7:0] irq_mask,
  input logic       spec_mask_mode,
  input logic       read_isr_sel,
  input logic       rot_in_aeoi,
  input logic       init_clr
);
  logic start_wr;
  assign start_wr = bus_sel && bus_wr && !bus_addr && bus_wdata[4];

  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (init_clr && !cfg_ready && irq_mask == '0 && !spec_mask_mode
                  && !read_isr_sel && !rot_in_aeoi));

  a_r3_clr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (init_clr && !start_wr) |=> !init_clr);

  a_r6_no_fourth_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !bus_wdata[0]) |=> ({cfg_aeoi, cfg_buf_master, cfg_buffered,
                                      cfg_sfnm, cfg_cpu16} == 5'b0));

  a_r7_mask_held_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ready && !start_wr) |=> $stable(irq_mask));

  a_r11_idle_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(cfg_ready));
endmodule

bind pic_init_seq pic_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cfg_ready(cfg_ready),
  .cfg_aeoi(cfg_aeoi), .cfg_buf_master(cfg_buf_master),
  .cfg_buffered(cfg_buffered), .cfg_sfnm(cfg_sfnm), .cfg_cpu16(cfg_cpu16),
  .irq_mask(irq_mask), .spec_mask_mode(spec_mask_mode),
  .read_isr_sel(read_isr_sel), .rot_in_aeoi(rot_in_aeoi), .init_clr(init_clr)
);

// File: tb/tb_pic_init_seq.sv
module tb_pic_init_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic cfg_ready, cfg_single, cfg_level, cfg_adi;
  logic [10:0] cfg_vec_base;
  logic [7:0] cfg_slave_map;
  logic [2:0] cfg_slave_id;
  logic cfg_aeoi, cfg_buf_master, cfg_buffered, cfg_sfnm, cfg_cpu16;
  logic [7:0] irq_mask;
  logic spec_mask_mode, read_isr_sel, rot_in_aeoi, init_clr, cmd_stb, poll_stb;
  logic [7:0] cmd_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_init_seq dut (.*);

  // bench model: 0 idle, 1 second, 2 third, 3 fourth, 4 running
  int   ms = 0;
  logic m_single = 0, m_level = 0, m_adi = 0, m_want4 = 0;
  logic [10:0] m_vec = '0;
  logic [7:0]  m_casc = '0, m_mask = '0, m_cmd = '0;
  logic [4:0]  m_opt = '0;
  logic m_smm = 0, m_risr = 0, m_rot = 0;
  logic e_clr, e_cmd, e_poll;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R7 ready", cfg_ready, ms == 4);
    chk("R2 flags", {cfg_single, cfg_level, cfg_adi}, {m_single, m_level, m_adi});
    chk("R4 vector", cfg_vec_base, m_vec);
    chk("R5 cascade", {cfg_slave_map, cfg_slave_id}, {m_casc, m_casc[2:0]});
    chk("R6 options", {cfg_sfnm, cfg_buffered, cfg_buf_master, cfg_aeoi, cfg_cpu16}, m_opt);
    chk("R8 mask", irq_mask, m_mask);
    chk("R10 op state", {spec_mask_mode, read_isr_sel}, {m_smm, m_risr});
    chk("R9 rotate", rot_in_aeoi, m_rot);
    chk("R3 clear pulse", init_clr, e_clr);
    chk("R9 cmd", {cmd_stb, cmd_byte}, {e_cmd, m_cmd});
    chk("R10 poll", poll_stb, e_poll);
  endtask

  function automatic void model(input logic s, input logic w, input logic a, input logic [7:0] d);
    e_clr = 0; e_cmd = 0; e_poll = 0;
    if (!(s && w)) return;                         // R11
    if (!a && d[4]) begin                          // R2, R3
      m_single = d[1]; m_adi = d[2]; m_level = d[3]; m_want4 = d[0];
      m_vec[2:0] = d[7:5]; m_opt = '0;
      m_mask = '0; m_smm = 0; m_risr = 0; m_rot = 0; e_clr = 1; ms = 1;
    end else if (a) begin
      case (ms)
        1: begin m_vec[10:3] = d; ms = !m_single ? 2 : (m_want4 ? 3 : 4); end
        2: begin m_casc = d; ms = m_want4 ? 3 : 4; end
        3: begin m_opt = {d[4], d[3], d[2], d[1], d[0]}; ms = 4; end
        4: m_mask = d;
        default: ;
      endcase
    end else if (ms == 4) begin
      m_cmd = d;
      if (!d[3]) begin
        e_cmd = 1;
        if (d[7:5] == 3'b100) m_rot = 1;
        if (d[7:5] == 3'b000) m_rot = 0;
      end else begin
        if (d[2]) e_poll = 1;
        else if (d[1]) m_risr = d[0];
        if (d[6]) m_smm = d[5];
      end
    end
  endfunction

  task automatic bus_write(input logic s, input logic w, input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    model(s, w, a, d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    check_all();
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    e_clr = 0; e_cmd = 0; e_poll = 0;
    repeat (3) @(negedge clk);
    check_all();                                   // R1 reset state
    rst_n = 1;
    // R7: writes before any start byte are ignored
    bus_write(1, 1, 1, 8'hAA);
    bus_write(1, 1, 0, 8'h0B);
    // R5 R6: cascade with fourth byte
    bus_write(1, 1, 0, 8'hB1);
    bus_write(1, 1, 1, 8'h44);
    bus_write(1, 1, 1, 8'h87);
    bus_write(1, 1, 1, 8'h1F);
    bus_write(1, 1, 1, 8'h5A);                     // R8 mask
    bus_write(1, 1, 0, 8'h80);                     // R9 rotate set
    bus_write(1, 1, 0, 8'h6B);                     // R10 smm + read isr
    bus_write(1, 1, 0, 8'h0E);                     // R10 poll overrides read
    bus_write(0, 1, 1, 8'hFF);                     // R11 no select
    bus_write(1, 0, 0, 8'h13);                     // R11 no strobe
    bus_write(1, 1, 0, 8'h00);                     // R9 rotate clear
    // R2 restart mid-sequence, R6 single without fourth
    bus_write(1, 1, 0, 8'h13);
    bus_write(1, 1, 1, 8'h22);
    bus_write(1, 1, 0, 8'h1A);                     // restart: single, no fourth
    bus_write(1, 1, 0, 8'h20);                     // R7 ignored in setup
    bus_write(1, 1, 1, 8'h99);
    bus_write(1, 1, 1, 8'h3C);
    // single with fourth
    bus_write(1, 1, 0, 8'hF3);
    bus_write(1, 1, 1, 8'h01);
    bus_write(1, 1, 1, 8'h0A);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] d;
      int k;
      d = 8'($urandom);
      k = $urandom_range(0, 9);
      if (k == 0) d[4] = 1;
      else if (k < 3) d[4] = 0;
      bus_write($urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
                k >= 5, (k >= 5 || k == 0) ? d : d);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule